// File: doc/BRIEF.md
# Secure/Normal Interrupt Router

The router collects level interrupt requests from a set of peripheral sources and delivers each one to exactly one of two handlers: the secure side, signalled on the fast-interrupt output, or the normal side, signalled on the regular interrupt output. Each source has a class held in a small configuration table. A source of the secure class always goes to the fast-interrupt line, so the normal side never observes it. Sources of the non-secure class always go to the regular line. Switchable sources go to the regular line unless the secure side has reserved them, and they return there when the secure side releases them.

A request is latched into a per-source pending bit. Each output line is high whenever any pending bit that belongs to its side is set. Each side clears its own pending bits with a write-one-to-clear mask. The class table and the reservations accept writes only when the access carries a low non-secure tag. Any write with the tag high is dropped, and an error flag is raised for one cycle.

Each switchable source has a two-state ownership machine. Its states are OWN_NORMAL, the reset state, and OWN_SECURE. The transition RESERVE moves the machine from OWN_NORMAL to OWN_SECURE, and only on a secure reserve command to a switchable source. The transition RELEASE moves it from OWN_SECURE back to OWN_NORMAL on a secure release command. The transition RECLASS moves it from either state to OWN_NORMAL on any secure class write to that source. The error flag has its own two-state machine. ERR_IDLE goes to ERR_FLAG on REJECT, which is a write with the tag high. ERR_FLAG goes back to ERR_IDLE on CALM, which is any cycle without such a write.

Top module: `irq_world_router`

## Requirements
- R1: After reset every source has class 00 and is owned by the normal side, no bit is pending, `fiq_o`, `irq_o` and `cfg_err_o` are low, and both pending vectors are zero.
- R2: A source input that is high at a rising clock edge sets that source's pending bit from that edge on. When a source is high and its bit is cleared in the same cycle, the set wins and the bit stays pending.
- R3: A pending source is routed as follows. Class 01 goes to the secure side (`pend_sec_o`, `fiq_o`). Class 00 and class 11 go to the normal side (`pend_nsec_o`, `irq_o`). Class 10 goes to the normal side unless the source is reserved.
- R4: A secure write with op 01 (reserve) to a class-10 source routes it to the secure side. Op 10 (release) routes it back to the normal side. A reserve to a source of any other class has no effect. Op 00 writes the class from `cfg_class`, and op 11 does nothing.
- R5: A configuration write with `cfg_ns` high changes neither the class nor the reservation, and `cfg_err_o` is high in the cycle after it. A write with `cfg_ns` low leaves `cfg_err_o` low in the next cycle.
- R6: A clear with `clr_ns` low removes only the masked pending bits that the secure side owns. A clear with `clr_ns` high removes only the masked bits that the normal side owns.
- R7: `fiq_o` is the OR of `pend_sec_o`, and `irq_o` is the OR of `pend_nsec_o`.
- R8: When ownership of a pending source changes, its pending bit appears on the new owner's side, and leaves the old one, in the cycle after the write.
- R9: A class write to a source drops any reservation the source holds.
- R10: A pending bit never shows on both sides at once. It is lost only through a clear from the side that owns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level interrupt requests, one per source |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ns | input | 1 | Non-secure tag of the write; high means rejected |
| cfg_op | input | 2 | 00 set class, 01 reserve, 10 release, 11 none |
| cfg_idx | input | IDXW | Source addressed by the write |
| cfg_class | input | 2 | Class value for op 00 |
| clr_valid | input | 1 | Pending-clear strobe |
| clr_ns | input | 1 | Side issuing the clear: 0 secure, 1 normal |
| clr_mask | input | NSRC | Write-one-to-clear mask |
| fiq_o | output | 1 | Secure fast-interrupt line |
| irq_o | output | 1 | Normal interrupt line |
| pend_sec_o | output | NSRC | Pending bits owned by the secure side |
| pend_nsec_o | output | NSRC | Pending bits owned by the normal side |
| cfg_err_o | output | 1 | Rejected-write flag, one cycle |

## Verification
The properties assume that `src_i`, `clr_valid`, `clr_mask` and `cfg_wr` stay low while reset is applied. They also assume that a clear and a configuration write never arrive in the same cycle, because otherwise a clear could hit a bit that is changing owner. The stimulus issues each configuration write, clear or source pulse in a cycle of its own, with only one exception. That exception is the deliberate case where a source pulse and a clear of the same bit coincide, which tests the rule that the set wins.

// File: rtl/irq_rt_pkg.sv
`timescale 1ns/1ps
package irq_rt_pkg;
    typedef enum logic [1:0] {
        CLS_NSEC   = 2'b00,
        CLS_SEC    = 2'b01,
        CLS_SWITCH = 2'b10,
        CLS_SPARE  = 2'b11
    } src_class_e;

    typedef enum logic [1:0] {
        OP_CLASS   = 2'b00,
        OP_RESERVE = 2'b01,
        OP_RELEASE = 2'b10,
        OP_NONE    = 2'b11
    } cfg_op_e;

    typedef enum logic {
        OWN_NORMAL = 1'b0,
        OWN_SECURE = 1'b1
    } owner_state_e;

    typedef enum logic {
        ERR_IDLE = 1'b0,
        ERR_FLAG = 1'b1
    } err_state_e;
endpackage

// File: rtl/irq_cfg_port.sv
`timescale 1ns/1ps
module irq_cfg_port
    import irq_rt_pkg::*;
#(
    parameter int NSRC = 16,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_ns,
    input  logic [1:0]      cfg_op,
    input  logic [IDXW-1:0] cfg_idx,
    output logic [NSRC-1:0] class_we,
    output logic [NSRC-1:0] rsv_set,
    output logic [NSRC-1:0] rsv_clr,
    output logic            err_o
);
    err_state_e err_q, err_d;
    logic       accept;

    assign accept = cfg_wr && !cfg_ns && (int'(cfg_idx) < NSRC);

    // Decode of accepted writes into per-source strobes.
    always_comb begin
        class_we = '0;
        rsv_set  = '0;
        rsv_clr  = '0;
        if (accept) begin
            unique case (cfg_op_e'(cfg_op))
                OP_CLASS:   class_we[cfg_idx] = 1'b1;
                OP_RESERVE: rsv_set[cfg_idx]  = 1'b1;
                OP_RELEASE: rsv_clr[cfg_idx]  = 1'b1;
                OP_NONE:    ;
            endcase
        end
    end

    // Error flag machine: REJECT enters ERR_FLAG, CALM returns to ERR_IDLE.
    always_comb begin
        unique case (err_q)
            ERR_IDLE: err_d = (cfg_wr && cfg_ns) ? ERR_FLAG : ERR_IDLE;
            ERR_FLAG: err_d = (cfg_wr && cfg_ns) ? ERR_FLAG : ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= ERR_IDLE;
        else        err_q <= err_d;
    end

    always_comb err_o = (err_q == ERR_FLAG);
endmodule

// File: rtl/irq_owner_fsm.sv
`timescale 1ns/1ps
module irq_owner_fsm
    import irq_rt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       class_we,
    input  logic [1:0] class_wdata,
    input  logic       rsv_set,
    input  logic       rsv_clr,
    output logic       to_secure
);
    src_class_e   cls_q;
    owner_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)        cls_q <= CLS_NSEC;
        else if (class_we) cls_q <= src_class_e'(class_wdata);
    end

    // Next state: RESERVE, RELEASE, RECLASS.
    always_comb begin
        unique case (st_q)
            OWN_NORMAL: st_d = (!class_we && rsv_set && cls_q == CLS_SWITCH)
                               ? OWN_SECURE : OWN_NORMAL;
            OWN_SECURE: st_d = (class_we || rsv_clr) ? OWN_NORMAL : OWN_SECURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OWN_NORMAL;
        else        st_q <= st_d;
    end

    always_comb to_secure = (cls_q == CLS_SEC) || (st_q == OWN_SECURE);
endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] to_sec,
    input  logic            clr_valid,
    input  logic            clr_ns,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] pend_sec,
    output logic [NSRC-1:0] pend_nsec
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] owned_by_clr;
    logic [NSRC-1:0] kill;

    assign owned_by_clr = clr_ns ? ~to_sec : to_sec;
    assign kill         = clr_valid ? (clr_mask & owned_by_clr) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~kill) | src_i;
    end

    assign pend_sec  = pend_q & to_sec;
    assign pend_nsec = pend_q & ~to_sec;
endmodule

// File: rtl/irq_world_router.sv
`timescale 1ns/1ps
module irq_world_router #(
    parameter int NSRC = 16,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            cfg_wr,
    input  logic            cfg_ns,
    input  logic [1:0]      cfg_op,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic [1:0]      cfg_class,
    input  logic            clr_valid,
    input  logic            clr_ns,
    input  logic [NSRC-1:0] clr_mask,
    output logic            fiq_o,
    output logic            irq_o,
    output logic [NSRC-1:0] pend_sec_o,
    output logic [NSRC-1:0] pend_nsec_o,
    output logic            cfg_err_o
);
    logic [NSRC-1:0] class_we, rsv_set, rsv_clr, to_sec;

    irq_cfg_port #(.NSRC(NSRC)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_ns   (cfg_ns),
        .cfg_op   (cfg_op),
        .cfg_idx  (cfg_idx),
        .class_we (class_we),
        .rsv_set  (rsv_set),
        .rsv_clr  (rsv_clr),
        .err_o    (cfg_err_o)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        irq_owner_fsm u_own (
            .clk         (clk),
            .rst_n       (rst_n),
            .class_we    (class_we[g]),
            .class_wdata (cfg_class),
            .rsv_set     (rsv_set[g]),
            .rsv_clr     (rsv_clr[g]),
            .to_secure   (to_sec[g])
        );
    end

    irq_pend_bank #(.NSRC(NSRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .to_sec    (to_sec),
        .clr_valid (clr_valid),
        .clr_ns    (clr_ns),
        .clr_mask  (clr_mask),
        .pend_sec  (pend_sec_o),
        .pend_nsec (pend_nsec_o)
    );

    assign fiq_o = |pend_sec_o;
    assign irq_o = |pend_nsec_o;
endmodule

// File: rtl/irq_world_router_chk.sv
`timescale 1ns/1ps
module irq_world_router_chk #(
    parameter int NSRC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic            cfg_wr,
    input logic            cfg_ns,
    input logic            clr_valid,
    input logic            clr_ns,
    input logic [NSRC-1:0] clr_mask,
    input logic [NSRC-1:0] pend_sec_o,
    input logic [NSRC-1:0] pend_nsec_o,
    input logic            cfg_err_o
);
    a_r2_request_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_sec_o | pend_nsec_o) & $past(src_i)) == $past(src_i)));

    a_r5_reject_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_ns) |=> cfg_err_o);

    a_r5_accept_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_ns) |=> !cfg_err_o);

    a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_sec_o & pend_nsec_o) == '0);

    a_r10_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_valid |=> (((pend_sec_o | pend_nsec_o) & $past(pend_sec_o | pend_nsec_o))
                        == $past(pend_sec_o | pend_nsec_o)));

    a_r6_secure_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !clr_ns && !cfg_wr) |=>
            ((pend_sec_o & $past(clr_mask) & ~$past(src_i)) == '0));

    a_r6_normal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && clr_ns && !cfg_wr) |=>
            ((pend_nsec_o & $past(clr_mask) & ~$past(src_i)) == '0));
endmodule

bind irq_world_router irq_world_router_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .cfg_wr      (cfg_wr),
    .cfg_ns      (cfg_ns),
    .clr_valid   (clr_valid),
    .clr_ns      (clr_ns),
    .clr_mask    (clr_mask),
    .pend_sec_o  (pend_sec_o),
    .pend_nsec_o (pend_nsec_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_irq_world_router.sv
`timescale 1ns/1ps
module tb_irq_world_router;
    localparam int NSRC = 16;
    localparam logic [1:0] OPC = 2'b00, OPR = 2'b01, OPL = 2'b10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            cfg_wr = 1'b0, cfg_ns = 1'b0;
    logic [1:0]      cfg_op = 2'b11, cfg_class = 2'b00;
    logic [3:0]      cfg_idx = '0;
    logic            clr_valid = 1'b0, clr_ns = 1'b0;
    logic [NSRC-1:0] clr_mask = '0;
    logic            fiq_o, irq_o, cfg_err_o;
    logic [NSRC-1:0] pend_sec_o, pend_nsec_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_world_router #(.NSRC(NSRC)) dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_pend(input logic [NSRC-1:0] sec, input logic [NSRC-1:0] nsec, input string req);
        check(pend_sec_o == sec, {req, " pend_sec"}, 32'(pend_sec_o), 32'(sec));
        check(pend_nsec_o == nsec, {req, " pend_nsec"}, 32'(pend_nsec_o), 32'(nsec));
        check(fiq_o == (|sec), {req, " R7 fiq"}, 32'(fiq_o), 32'(|sec));
        check(irq_o == (|nsec), {req, " R7 irq"}, 32'(irq_o), 32'(|nsec));
        check((pend_sec_o & pend_nsec_o) == '0, {req, " R10 disjoint"}, 32'(pend_sec_o & pend_nsec_o), 32'h0);
    endtask

    task automatic cfg(input logic ns, input logic [1:0] op, input int idx, input logic [1:0] cls);
        cfg_wr = 1'b1; cfg_ns = ns; cfg_op = op; cfg_idx = 4'(idx); cfg_class = cls;
        tick();
        cfg_wr = 1'b0; cfg_op = 2'b11;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        src_i = m;
        tick();
        src_i = '0;
    endtask

    task automatic clr(input logic ns, input logic [NSRC-1:0] m);
        clr_valid = 1'b1; clr_ns = ns; clr_mask = m;
        tick();
        clr_valid = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset();
        check_pend('0, '0, "R1");
        check(cfg_err_o == 1'b0, "R1 err", 32'(cfg_err_o), 32'h0);
    endtask

    task automatic t_route();
        pulse(16'h0008);
        check_pend('0, 16'h0008, "R3 class00");
        cfg(1'b0, OPC, 5, 2'b01);
        pulse(16'h0020);
        check_pend(16'h0020, 16'h0008, "R3 class01");
        cfg(1'b0, OPC, 7, 2'b11);
        pulse(16'h0080);
        check_pend(16'h0020, 16'h0088, "R3 class11");
    endtask

    task automatic t_clear();
        clr(1'b1, 16'h0020);
        check_pend(16'h0020, 16'h0088, "R6 normal cannot clear secure");
        clr(1'b0, 16'h0088);
        check_pend(16'h0020, 16'h0088, "R6 secure cannot clear normal");
        clr(1'b0, 16'h0020);
        check_pend('0, 16'h0088, "R6 secure clear");
        clr(1'b1, 16'h0088);
        check_pend('0, '0, "R6 normal clear");
    endtask

    task automatic t_reject();
        cfg(1'b1, OPC, 2, 2'b01);
        check(cfg_err_o == 1'b1, "R5 err raised", 32'(cfg_err_o), 32'h1);
        pulse(16'h0004);
        check(cfg_err_o == 1'b0, "R5 err drops", 32'(cfg_err_o), 32'h0);
        check_pend('0, 16'h0004, "R5 class unchanged");
        cfg(1'b0, OPC, 2, 2'b01);
        check(cfg_err_o == 1'b0, "R5 secure no err", 32'(cfg_err_o), 32'h0);
        check_pend(16'h0004, '0, "R8 reclass moves pending");
        clr(1'b0, 16'h0004);
        cfg(1'b0, OPC, 2, 2'b00);
        check_pend('0, '0, "R6 cleanup");
    endtask

    task automatic t_switch();
        cfg(1'b0, OPC, 9, 2'b10);
        pulse(16'h0200);
        check_pend('0, 16'h0200, "R3 switchable unreserved");
        cfg(1'b1, OPR, 9, 2'b00);
        check(cfg_err_o == 1'b1, "R5 reserve rejected", 32'(cfg_err_o), 32'h1);
        check_pend('0, 16'h0200, "R5 reserve ignored");
        cfg(1'b0, OPR, 9, 2'b00);
        check_pend(16'h0200, '0, "R8 R4 reserve moves pending");
        pulse(16'h0200);
        check_pend(16'h0200, '0, "R4 reserved stays secure");
        cfg(1'b0, OPL, 9, 2'b00);
        check_pend('0, 16'h0200, "R8 R4 release moves back");
        clr(1'b1, 16'h0200);
        cfg(1'b0, OPR, 3, 2'b00);
        pulse(16'h0008);
        check_pend('0, 16'h0008, "R4 reserve on class00 ignored");
        clr(1'b1, 16'h0008);
        check_pend('0, '0, "R6 cleanup");
    endtask

    task automatic t_reclass();
        cfg(1'b0, OPR, 9, 2'b00);
        pulse(16'h0200);
        check_pend(16'h0200, '0, "R4 reserved again");
        cfg(1'b0, OPC, 9, 2'b10);
        check_pend('0, 16'h0200, "R9 class write drops reservation");
        clr(1'b1, 16'h0200);
        check_pend('0, '0, "R9 cleanup");
    endtask

    task automatic t_setwins();
        pulse(16'h0008);
        src_i = 16'h0008;
        clr(1'b1, 16'h0008);
        src_i = '0;
        check_pend('0, 16'h0008, "R2 set wins over clear");
        clr(1'b1, 16'h0008);
        check_pend('0, '0, "R2 later clear");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_route();
        t_clear();
        t_reject();
        t_switch();
        t_reclass();
        t_setwins();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule